// File: doc/BRIEF.md
# Eight-Segment Space Vector Sequencer

This block drives the three bridge legs of a two-level, three-phase converter through one switching period at a time. It takes a sector number, the duty fractions of the two active vectors that bound the sector, a split factor for the zero-vector time, and a period length in clock ticks. From these it works out how many ticks each vector occupies. It then plays a symmetric sequence: all-low zero vector, first active vector, second active vector, all-high zero vector, and back in mirror order. A period counter and a segment state machine produce the three-bit leg state on every clock.

The split factor moves zero-vector time between the all-high and all-low vectors. Setting it to zero or to one clamps the period to a single zero vector, so one leg stops switching for that period. When the two active duties sum to more than one, both are scaled down in proportion so that they fill the whole period, and a flag marks the period as overmodulated. The inputs are sampled only at a period boundary, and a pulse marks the first tick of every period.

The state machine has nine states. IDLE is held only during reset. The eight segment states, in play order, are Z8_LEAD, A_LEAD, B_LEAD, Z7_LEAD, Z7_TRAIL, B_TRAIL, A_TRAIL and Z8_TRAIL. There are three kinds of transition. *Dwell* keeps the state while the tick counter runs down. *Advance* moves to the next later segment whose length is not zero. *Wrap* is taken from IDLE, or when no later segment has ticks left; it samples new inputs and enters the first non-empty segment of the new period.

Top module: `svs_sequencer`

## Requirements
- R1: `legs_o` bit 2 is phase a, bit 1 is phase b and bit 0 is phase c, and a 1 means that leg's upper switch is on. For sectors 1 to 6, the first active vector (A) and the second active vector (B) are: 1: 100/110; 2: 010/110; 3: 010/011; 4: 001/011; 5: 001/101; 6: 100/101. The zero vectors are 000 and 111.
- R2: Each period plays its segments in this order: 000, A, B, 111, 111, B, A, 000. Segments of zero length are skipped. When both leading active halves are non-empty, consecutive ticks inside a period differ in at most one bit.
- R3: Duties are unsigned 16-bit fractions of one. Outside overmodulation, A takes floor(dA·P/65536) ticks and B takes floor(dB·P/65536) ticks. Each active time T is split into a leading half of floor(T/2) and a trailing half of T − floor(T/2).
- R4: The zero time is Z = P − tA − tB. The all-high time is floor(k·Z/65536), where k is a 17-bit value with 65536 meaning one and larger values clamped to 65536. The all-low time gets the rest of Z. Each zero time is split with the floor half leading.
- R5: When the sampled k is 0, the value 111 never appears. When the sampled k is 65536 or more, the value 000 never appears.
- R6: Every period lasts exactly P ticks. `period_start_o` is 1 on the first tick of each period only (P=1 gives a pulse every tick).
- R7: Inputs are sampled only at the clock edge that starts a period. Changes made between those edges have no effect on the period in progress.
- R8: In a valid sector with dA + dB > 65536, tA = floor(dA·P/(dA+dB)) and tB = P − tA. No zero vector is played, and `overmod_o` is 1 for that whole period. A sum of exactly 65536 is not overmodulation.
- R9: A sector value of 0 or 7 plays only zero vectors for the whole period, split by k, with `overmod_o` at 0.
- R10: During reset the outputs are 000, 0 and 0. The first period begins on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sector_i | input | 3 | Sector number, 1 to 6 valid |
| duty_a_i | input | DUTY_W | Duty of the first active vector, fraction of one |
| duty_b_i | input | DUTY_W | Duty of the second active vector, fraction of one |
| zsplit_i | input | DUTY_W+1 | Share of zero time given to 111; 2^DUTY_W means one |
| period_i | input | PER_W | Period length in clock ticks |
| legs_o | output | 3 | Leg switching state, phase a in bit 2 |
| period_start_o | output | 1 | High on the first tick of each period |
| overmod_o | output | 1 | The current period was overmodulated |

## Verification
The assertions assume a period length of at least one tick. A zero period has no defined length, so the period-length and single-zero-vector properties would not hold for it. The one-leg-per-boundary property is checked only when both leading active halves are non-empty, because skipping an empty active segment joins two vectors that are two bits apart. The stimulus never drives a zero period, changes inputs only on falling clock edges, and includes empty active segments so that this exception is exercised rather than avoided.

// File: rtl/svs_pkg.sv
package svs_pkg;

    localparam int NUM_SEGS = 8;

    localparam logic [2:0] VEC_ALL_LOW  = 3'b000;
    localparam logic [2:0] VEC_ALL_HIGH = 3'b111;

    // Segment states in play order; the low three bits index the segment.
    typedef enum logic [3:0] {
        SEG_Z8_LEAD  = 4'd0,
        SEG_A_LEAD   = 4'd1,
        SEG_B_LEAD   = 4'd2,
        SEG_Z7_LEAD  = 4'd3,
        SEG_Z7_TRAIL = 4'd4,
        SEG_B_TRAIL  = 4'd5,
        SEG_A_TRAIL  = 4'd6,
        SEG_Z8_TRAIL = 4'd7,
        SEG_IDLE     = 4'd8
    } seg_state_t;

endpackage

// File: rtl/svs_vector_lut.sv
module svs_vector_lut (
    input  logic [2:0] sector_i,
    output logic [2:0] vec_a_o,
    output logic [2:0] vec_b_o,
    output logic       valid_o
);

    // A is the single-upper vector of the sector, B the double-upper one,
    // so that 000 -> A -> B -> 111 changes one leg per step (R1, R2).
    always_comb begin
        valid_o = 1'b1;
        unique case (sector_i)
            3'd1: begin vec_a_o = 3'b100; vec_b_o = 3'b110; end
            3'd2: begin vec_a_o = 3'b010; vec_b_o = 3'b110; end
            3'd3: begin vec_a_o = 3'b010; vec_b_o = 3'b011; end
            3'd4: begin vec_a_o = 3'b001; vec_b_o = 3'b011; end
            3'd5: begin vec_a_o = 3'b001; vec_b_o = 3'b101; end
            3'd6: begin vec_a_o = 3'b100; vec_b_o = 3'b101; end
            default: begin
                vec_a_o = 3'b000;
                vec_b_o = 3'b000;
                valid_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/svs_dwell_calc.sv
module svs_dwell_calc
    import svs_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int DUTY_W = 16
) (
    input  logic [PER_W-1:0]                 period_i,
    input  logic [DUTY_W-1:0]                duty_a_i,
    input  logic [DUTY_W-1:0]                duty_b_i,
    input  logic [DUTY_W:0]                  zsplit_i,
    input  logic                             sector_ok_i,
    output logic [NUM_SEGS-1:0][PER_W-1:0]   seg_len_o,
    output logic                             overmod_o
);

    localparam int PROD_W  = DUTY_W + PER_W;
    localparam int KPROD_W = DUTY_W + 1 + PER_W;
    localparam logic [DUTY_W:0] UNITY = (DUTY_W+1)'(1) << DUTY_W;

    logic [DUTY_W:0]   dsum;
    logic [PROD_W-1:0] prod_a;
    logic [PROD_W-1:0] prod_b;
    logic [PROD_W-1:0] divisor;
    logic [PROD_W-1:0] quo_a;
    logic              over;
    logic [PER_W-1:0]  t_a;
    logic [PER_W-1:0]  t_b;
    logic [PER_W-1:0]  t_zero;
    logic [PER_W-1:0]  t_high;
    logic [PER_W-1:0]  t_low;
    logic [DUTY_W:0]   k_eff;
    logic [KPROD_W-1:0] kprod;
    logic [PER_W-1:0]  h_a;
    logic [PER_W-1:0]  h_b;
    logic [PER_W-1:0]  h_high;
    logic [PER_W-1:0]  h_low;

    always_comb begin
        dsum    = {1'b0, duty_a_i} + {1'b0, duty_b_i};
        prod_a  = PROD_W'(duty_a_i) * PROD_W'(period_i);
        prod_b  = PROD_W'(duty_b_i) * PROD_W'(period_i);
        over    = sector_ok_i && (dsum > UNITY);
        divisor = over ? PROD_W'(dsum) : PROD_W'(1);
        quo_a   = prod_a / divisor;

        if (!sector_ok_i) begin
            t_a = '0;
            t_b = '0;
        end else if (over) begin
            // Proportional scaling: active vectors fill the whole period (R8)
            t_a = quo_a[PER_W-1:0];
            t_b = period_i - t_a;
        end else begin
            t_a = prod_a[PROD_W-1:DUTY_W];
            t_b = prod_b[PROD_W-1:DUTY_W];
        end

        t_zero = period_i - t_a - t_b;
        k_eff  = (zsplit_i > UNITY) ? UNITY : zsplit_i;
        kprod  = KPROD_W'(k_eff) * KPROD_W'(t_zero);
        t_high = kprod[DUTY_W+PER_W-1:DUTY_W];
        t_low  = t_zero - t_high;

        h_a    = t_a >> 1;
        h_b    = t_b >> 1;
        h_high = t_high >> 1;
        h_low  = t_low >> 1;

        seg_len_o[0] = h_low;
        seg_len_o[1] = h_a;
        seg_len_o[2] = h_b;
        seg_len_o[3] = h_high;
        seg_len_o[4] = t_high - h_high;
        seg_len_o[5] = t_b - h_b;
        seg_len_o[6] = t_a - h_a;
        seg_len_o[7] = t_low - h_low;
        overmod_o    = over;
    end

endmodule

// File: rtl/svs_seg_fsm.sv
module svs_seg_fsm
    import svs_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SEGS-1:0][PER_W-1:0]  seg_len_i,
    output seg_state_t                      state_o,
    output logic                            load_o,
    output logic                            start_o,
    output logic [NUM_SEGS-1:0][PER_W-1:0]  seg_len_o
);

    localparam int IDX_W = $clog2(NUM_SEGS);

    seg_state_t                     state_q;
    seg_state_t                     state_d;
    logic [PER_W-1:0]               cnt_q;
    logic [PER_W-1:0]               cnt_d;
    logic [NUM_SEGS-1:0][PER_W-1:0] len_q;
    logic                           start_q;
    logic                           load;
    logic [3:0]                     st_raw;
    logic [IDX_W-1:0]               cur_idx;
    logic [IDX_W-1:0]               nxt_idx;
    logic [IDX_W-1:0]               first_idx;
    logic                           nxt_found;
    logic                           first_found;

    // Search for the next non-empty segment of this period, and for the
    // first non-empty segment of the period about to be loaded.
    always_comb begin
        st_raw      = 4'(state_q);
        cur_idx     = st_raw[IDX_W-1:0];
        nxt_found   = 1'b0;
        nxt_idx     = '0;
        first_found = 1'b0;
        first_idx   = '0;
        for (int i = NUM_SEGS - 1; i >= 0; i--) begin
            if ((i > int'(cur_idx)) && (len_q[i] != '0)) begin
                nxt_found = 1'b1;
                nxt_idx   = IDX_W'(i);
            end
            if (seg_len_i[i] != '0) begin
                first_found = 1'b1;
                first_idx   = IDX_W'(i);
            end
        end
    end

    // Transitions: dwell, advance, wrap
    always_comb begin
        load    = (state_q == SEG_IDLE) || ((cnt_q == '0) && !nxt_found);
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load) begin
            state_d = seg_state_t'(4'(first_idx));
            cnt_d   = first_found ? (seg_len_i[first_idx] - PER_W'(1)) : '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - PER_W'(1);
        end else begin
            state_d = seg_state_t'(4'(nxt_idx));
            cnt_d   = len_q[nxt_idx] - PER_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEG_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            start_q <= load;
            if (load) begin
                len_q <= seg_len_i;
            end
        end
    end

    assign state_o   = state_q;
    assign load_o    = load;
    assign start_o   = start_q;
    assign seg_len_o = len_q;

endmodule

// File: rtl/svs_sequencer.sv
module svs_sequencer
    import svs_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int DUTY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sector_i,
    input  logic [DUTY_W-1:0] duty_a_i,
    input  logic [DUTY_W-1:0] duty_b_i,
    input  logic [DUTY_W:0]   zsplit_i,
    input  logic [PER_W-1:0]  period_i,
    output logic [2:0]        legs_o,
    output logic              period_start_o,
    output logic              overmod_o
);

    logic [2:0]                     live_a;
    logic [2:0]                     live_b;
    logic                           sector_ok;
    logic [NUM_SEGS-1:0][PER_W-1:0] live_len;
    logic                           live_ovm;
    seg_state_t                     state;
    logic                           load;
    logic                           start_q;
    logic [NUM_SEGS-1:0][PER_W-1:0] len_q;

    logic [2:0]        code_a_q;
    logic [2:0]        code_b_q;
    logic              ovm_q;
    logic [DUTY_W:0]   k_q;
    logic [PER_W-1:0]  per_q;

    svs_vector_lut u_lut (
        .sector_i (sector_i),
        .vec_a_o  (live_a),
        .vec_b_o  (live_b),
        .valid_o  (sector_ok)
    );

    svs_dwell_calc #(
        .PER_W  (PER_W),
        .DUTY_W (DUTY_W)
    ) u_calc (
        .period_i    (period_i),
        .duty_a_i    (duty_a_i),
        .duty_b_i    (duty_b_i),
        .zsplit_i    (zsplit_i),
        .sector_ok_i (sector_ok),
        .seg_len_o   (live_len),
        .overmod_o   (live_ovm)
    );

    svs_seg_fsm #(
        .PER_W (PER_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg_len_i (live_len),
        .state_o   (state),
        .load_o    (load),
        .start_o   (start_q),
        .seg_len_o (len_q)
    );

    // Inputs are sampled only at a period boundary (R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_a_q <= '0;
            code_b_q <= '0;
            ovm_q    <= 1'b0;
            k_q      <= '0;
            per_q    <= '0;
        end else if (load) begin
            code_a_q <= live_a;
            code_b_q <= live_b;
            ovm_q    <= live_ovm;
            k_q      <= zsplit_i;
            per_q    <= period_i;
        end
    end

    // Output decode from the segment state
    always_comb begin
        unique case (state)
            SEG_Z8_LEAD, SEG_Z8_TRAIL: legs_o = VEC_ALL_LOW;
            SEG_A_LEAD,  SEG_A_TRAIL:  legs_o = code_a_q;
            SEG_B_LEAD,  SEG_B_TRAIL:  legs_o = code_b_q;
            SEG_Z7_LEAD, SEG_Z7_TRAIL: legs_o = VEC_ALL_HIGH;
            default:                   legs_o = VEC_ALL_LOW;
        endcase
        period_start_o = start_q;
        overmod_o      = ovm_q;
    end

endmodule

// File: rtl/svs_sequencer_chk.sv
module svs_sequencer_chk #(
    parameter int PW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    legs_i,
    input logic          start_i,
    input logic          ovm_i,
    input logic [DW:0]   k_lat_i,
    input logic [PW-1:0] per_lat_i,
    input logic [PW-1:0] len_a_i,
    input logic [PW-1:0] len_b_i
);

    localparam logic [DW:0] UNITY = (DW+1)'(1) << DW;

    logic [PW:0]   cyc;
    logic [PW-1:0] last_per;
    logic          seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc      <= '0;
            last_per <= '0;
            seen     <= 1'b0;
        end else begin
            last_per <= per_lat_i;
            if (start_i) begin
                cyc  <= (PW+1)'(1);
                seen <= 1'b1;
            end else begin
                cyc <= cyc + (PW+1)'(1);
            end
        end
    end

    // R6: distance between period pulses equals the sampled period
    a_r6_period_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && seen) |-> (cyc == {1'b0, last_per}));

    // R2: at most one leg changes inside a period with both active halves present
    a_r2_one_leg: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && (len_a_i != '0) && (len_b_i != '0))
        |-> ($countones(legs_i ^ $past(legs_i)) <= 1));

    // R5: k of zero never plays the all-high vector
    a_r5_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        (k_lat_i == '0) |-> (legs_i != 3'b111));

    // R5: k of one or more never plays the all-low vector
    a_r5_no_low: assert property (@(posedge clk) disable iff (!rst_n)
        (k_lat_i >= UNITY) |-> (legs_i != 3'b000));

    // R8: an overmodulated period contains no zero vector
    a_r8_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovm_i |-> ((legs_i != 3'b000) && (legs_i != 3'b111)));

    // R10: outputs quiet while reset is held
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> ((legs_i == 3'b000) && !start_i && !ovm_i));

endmodule

bind svs_sequencer svs_sequencer_chk #(
    .PW (PER_W),
    .DW (DUTY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .legs_i    (legs_o),
    .start_i   (period_start_o),
    .ovm_i     (overmod_o),
    .k_lat_i   (k_q),
    .per_lat_i (per_q),
    .len_a_i   (len_q[1]),
    .len_b_i   (len_q[2])
);

// File: tb/sim_svs_sequencer.sv
module sim_svs_sequencer;

    localparam int PW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    sector_i = '0;
    logic [DW-1:0] duty_a_i = '0;
    logic [DW-1:0] duty_b_i = '0;
    logic [DW:0]   zsplit_i = '0;
    logic [PW-1:0] period_i = '0;
    logic [2:0]    legs_o;
    logic          period_start_o;
    logic          overmod_o;

    svs_sequencer #(.PER_W(PW), .DUTY_W(DW)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .sector_i       (sector_i),
        .duty_a_i       (duty_a_i),
        .duty_b_i       (duty_b_i),
        .zsplit_i       (zsplit_i),
        .period_i       (period_i),
        .legs_o         (legs_o),
        .period_start_o (period_start_o),
        .overmod_o      (overmod_o)
    );

    always #10 clk = ~clk;

    logic [4:0] exp_q[$];
    string      tag_q[$];
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    bit         synced = 1'b0;
    int         pending = 0;
    int         prev_per = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R1 encodings, phase a in bit 2
    function automatic logic [2:0] act_code(input int sec, input bit second);
        case (sec)
            1: return second ? 3'b110 : 3'b100;
            2: return second ? 3'b110 : 3'b010;
            3: return second ? 3'b011 : 3'b010;
            4: return second ? 3'b011 : 3'b001;
            5: return second ? 3'b101 : 3'b001;
            6: return second ? 3'b101 : 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    // Driver: queue the expected ticks of nper periods (R2, R3, R4, R8, R9)
    task automatic push_cfg(input int sec, input longint da, input longint db,
                            input longint k, input longint per, input int nper,
                            input string tag);
        longint ta, tb, z, kc, th, tl;
        longint len[8];
        logic [2:0] code[8];
        bit ok, ovm;
        ok  = (sec >= 1) && (sec <= 6);
        ovm = 1'b0;
        if (!ok) begin
            ta = 0; tb = 0;
        end else if (da + db > 65536) begin
            ovm = 1'b1;
            ta  = (da * per) / (da + db);
            tb  = per - ta;
        end else begin
            ta = (da * per) >> 16;
            tb = (db * per) >> 16;
        end
        z  = per - ta - tb;
        kc = (k > 65536) ? 65536 : k;
        th = (kc * z) >> 16;
        tl = z - th;
        len[0] = tl / 2;  len[7] = tl - tl / 2;
        len[1] = ta / 2;  len[6] = ta - ta / 2;
        len[2] = tb / 2;  len[5] = tb - tb / 2;
        len[3] = th / 2;  len[4] = th - th / 2;
        code[0] = 3'b000; code[7] = 3'b000;
        code[3] = 3'b111; code[4] = 3'b111;
        code[1] = act_code(sec, 1'b0); code[6] = code[1];
        code[2] = act_code(sec, 1'b1); code[5] = code[2];
        for (int p = 0; p < nper; p++) begin
            bit first;
            first = 1'b1;
            for (int s = 0; s < 8; s++) begin
                for (longint t = 0; t < len[s]; t++) begin
                    exp_q.push_back({code[s], first, ovm});
                    // last period also witnesses the input glitch of R7
                    tag_q.push_back((p == nper - 1) ? {tag, " R6 R7"} : {tag, " R6"});
                    first = 1'b0;
                end
            end
        end
    endtask

    task automatic apply(input int sec, input int da, input int db, input int k, input int per);
        sector_i = 3'(sec);
        duty_a_i = DW'(da);
        duty_b_i = DW'(db);
        zsplit_i = (DW+1)'(k);
        period_i = PW'(per);
    endtask

    task automatic wait_starts(input int n);
        int c;
        c = 0;
        while (c < n) begin
            @(negedge clk);
            if (period_start_o) c++;
        end
    endtask

    // Apply a new setting during the last period of the previous one, then
    // disturb the inputs briefly before they are sampled (R7).
    task automatic next_cfg(input int sec, input int da, input int db, input int k,
                            input int per, input int nper, input string tag);
        logic [2:0]    s_sec;
        logic [DW-1:0] s_a;
        wait_starts(pending);
        apply(sec, da, db, k, per);
        push_cfg(sec, da, db, k, per, nper, tag);
        if (prev_per >= 6) begin
            @(negedge clk);
            s_sec    = sector_i;
            s_a      = duty_a_i;
            sector_i = ~s_sec;
            duty_a_i = ~s_a;
            period_i = PW'(3);
            @(negedge clk);
            sector_i = s_sec;
            duty_a_i = s_a;
            period_i = PW'(per);
        end
        pending  = nper;
        prev_per = per;
    endtask

    // Monitor: pop one expected tick per clock once the first period starts
    always @(negedge clk) begin
        logic [4:0] got;
        logic [4:0] want;
        string      tg;
        if (rst_n && !done) begin
            if (!synced && period_start_o) synced = 1'b1;
            if (synced && exp_q.size() > 0) begin
                got  = {legs_o, period_start_o, overmod_o};
                want = exp_q.pop_front();
                tg   = tag_q.pop_front();
                check(got == want, tg, int'(got), int'(want));
            end
        end
    end

    initial begin
        apply(1, 'h4000, 'h2000, 'h8000, 100);
        push_cfg(1, 'h4000, 'h2000, 'h8000, 100, 2, "R1 R2 R3 R4");
        prev_per = 100;
        repeat (4) begin
            @(negedge clk);
            check({legs_o, period_start_o, overmod_o} == 5'b0, "R10 reset outputs",
                  int'({legs_o, period_start_o, overmod_o}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(period_start_o == 1'b1, "R10 first period after release",
              int'(period_start_o), 1);
        pending = 1;
        next_cfg(2, 'h3000, 'h3000, 'h0,     64,  2, "R1 R5 k=0");
        next_cfg(3, 'h2000, 'h5000, 'h10000, 90,  2, "R1 R5 k=1");
        next_cfg(4, 'hC000, 'h8000, 'h8000,  60,  2, "R8 scaled");
        next_cfg(5, 'h0,    'h4000, 'h4000,  50,  2, "R2 R3 empty A");
        next_cfg(0, 'h4000, 'h4000, 'h8000,  33,  2, "R9 sector 0");
        next_cfg(6, 'h1234, 'h2345, 'h18000, 77,  2, "R4 R5 clamp");
        next_cfg(1, 'h8000, 'h8000, 'h8000,  40,  1, "R8 sum exactly one");
        next_cfg(2, 'h0100, 'h0100, 'h8000,  1,   3, "R6 one tick");
        next_cfg(7, 'h4000, 'h1000, 'h4000,  20,  1, "R9 sector 7");
        next_cfg(3, 'hFFFF, 'hFFFF, 'h0,     7,   2, "R8 full scale");
        next_cfg(4, 'h5555, 'h2AAA, 'h6000,  255, 1, "R3 R4 odd");
        wait_starts(pending);
        while (exp_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=%0d expected=0 pending ticks", exp_q.size());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule